// File: doc/BRIEF.md
# UART Interrupt Status and Priority Logic

This block collects the interrupt sources of a 16550-style UART and turns them into one interrupt line and the low part of the interrupt identification value that the CPU reads. It sits between the receive FIFO, the transmit FIFO, the error flags of the receiver and the CPU register decoder. Three sources are handled: receive line errors, receive data ready and transmit ready. Each source has its own enable bit. When several sources are pending, only the most urgent one is reported.

The receive source is a level. In FIFO mode it is pending while the fill count is at or above a programmable trigger. In single-register mode it is pending while any character is held. It clears itself as soon as that condition stops. The transmit source behaves differently: it is an event latched when the transmit storage goes empty. The CPU clears it by writing new data, or by reading the identification value while transmit ready is the source reported there. Line errors are latched and cleared by a read of the line status register. The block also produces the data-ready status bit.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset no source is pending. `isrValue[3:0]` is 0001, `irqOut` is 0 and `dataReady` is 0.
- R2: With `fifoEn`=1 and `intEnable[0]`=1, receive ready is pending in the same cycle that `rxCount >= rxTrigger`. It is reported as code 0100 and stops being reported once the count falls below the trigger.
- R3: With `fifoEn`=0, receive ready is pending whenever `rxCount` is nonzero, whatever the value of `rxTrigger`.
- R4: `dataReady` rises on the clock edge at which `rxPush` is high. It stays set while `rxCount` is nonzero, even below the trigger. It falls on an edge at which `rxCount` is 0 and `rxPush` is low.
- R5: A clock edge that sees `txEmpty` high after a cycle in which it was low latches a transmit event. The event is reported as code 0100's lower neighbour, code 0010. The event stays latched while `txEmpty` remains high. Leaving reset with `txEmpty` already high latches nothing.
- R6: A pending transmit event clears on an edge with `thrWrite` high. It also clears on an edge with `isrRead` high, but only if code 0010 is the reported code in that cycle. An `isrRead` while another code is reported leaves the event pending.
- R7: Any bit of `errFlags` high at an edge latches a line error, reported as code 0110 when `intEnable[2]`=1. An edge with `lsrRead` high clears the latched errors, except for any flag arriving in that same cycle, which stays latched.
- R8: The priority order is line error (0110), then receive ready (0100), then transmit ready (0010). Code 0001 means nothing enabled is pending.
- R9: A source whose enable bit is 0 is neither reported nor drives `irqOut`. Its latched state is kept, so enabling it later reports it at once. Enable bit 0 is receive, bit 1 is transmit and bit 2 is line error.
- R10: `irqOut` is high exactly when some enabled source is pending. `isrValue[7:6]` is 11 when `fifoEn`=1 and 00 otherwise. `isrValue[5:4]` is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1 selects FIFO mode, 0 selects single holding register mode |
| intEnable | input | 3 | Enable bits: bit 0 receive, bit 1 transmit, bit 2 line error |
| rxCount | input | CNT_W | Current receive FIFO fill count |
| rxTrigger | input | CNT_W | Programmed receive trigger level |
| rxPush | input | 1 | A character moves from the receive shifter into storage |
| errFlags | input | ERR_W | Error events from the receiver (overrun, parity, framing, break) |
| txEmpty | input | 1 | Transmit holding register or transmit FIFO is empty |
| isrRead | input | 1 | CPU reads the interrupt identification value |
| lsrRead | input | 1 | CPU reads the line status register |
| thrWrite | input | 1 | CPU writes the transmit holding register |
| irqOut | output | 1 | Interrupt request line |
| isrValue | output | 8 | Interrupt identification value |
| dataReady | output | 1 | Receive data-ready status bit |

## Verification
The bench checks the trigger boundary from both sides. A compare off by one would assert one character early, or stay asserted at trigger minus one. It confirms that in single-register mode the trigger value has no effect on the receive source.

The bench reads the identification value while receive ready hides a pending transmit event. A design that clears the transmit event on any read would then lose it, and code 0010 would not appear once the receive condition drops.

The bench also places an error flag in the same cycle as a line status read. A design that lets the clear win would drop that error. Finally, it checks that a source latched while disabled appears as soon as its enable bit is set.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ISR_LINE  = 4'b0110,
    ISR_RXRDY = 4'b0100,
    ISR_TXRDY = 4'b0010,
    ISR_NONE  = 4'b0001
  } isr_code_e;

  // pending sources before enable gating
  typedef struct packed {
    logic line;
    logic rx;
    logic tx;
  } src_vec_t;

  // control to datapath
  typedef struct packed {
    logic clrTx;
    logic clrLine;
  } irq_strobe_t;

endpackage

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             rxPush,
  input  logic [ERR_W-1:0] errFlags,
  input  logic             txEmpty,
  input  irq_strobe_t      strobes,
  output src_vec_t         rawPend,
  output logic             dataRdy
);

  logic             txPrev;
  logic             txPend;
  logic [ERR_W-1:0] errLatch;
  logic             rxLevel;
  logic             txRise;

  assign txRise = txEmpty & ~txPrev;

  // receive level: trigger compare in FIFO mode, any data otherwise
  always_comb begin
    if (fifoEn) rxLevel = (rxCount >= rxTrigger);
    else        rxLevel = (rxCount != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPrev   <= 1'b1;
      txPend   <= 1'b0;
      errLatch <= '0;
      dataRdy  <= 1'b0;
    end else begin
      txPrev <= txEmpty;
      if (txRise)             txPend <= 1'b1;
      else if (strobes.clrTx) txPend <= 1'b0;
      if (strobes.clrLine) errLatch <= errFlags;
      else                 errLatch <= errLatch | errFlags;
      if (rxPush)                dataRdy <= 1'b1;
      else if (rxCount == '0)    dataRdy <= 1'b0;
    end
  end

  assign rawPend.line = |errLatch;
  assign rawPend.rx   = rxLevel;
  assign rawPend.tx   = txPend;

  a_r4_push_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> dataRdy);
  a_r4_empty_clears: assert property (@(posedge clk) disable iff (!rstN)
    (!rxPush && rxCount == '0) |=> !dataRdy);
  a_r7_new_error_kept: assert property (@(posedge clk) disable iff (!rstN)
    (|errFlags) |=> rawPend.line);
  a_r5_rise_latches: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !txPrev) |=> txPend);

endmodule

// File: rtl/uart_irq_control.sv
module uart_irq_control
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  intEnable,
  input  src_vec_t    rawPend,
  input  logic        isrRead,
  input  logic        lsrRead,
  input  logic        thrWrite,
  output irq_strobe_t strobes,
  output isr_code_e   code,
  output logic        irq
);

  src_vec_t enPend;

  always_comb begin
    enPend.line = rawPend.line & intEnable[2];
    enPend.rx   = rawPend.rx   & intEnable[0];
    enPend.tx   = rawPend.tx   & intEnable[1];
    irq = enPend.line | enPend.rx | enPend.tx;
    if (enPend.line)    code = ISR_LINE;
    else if (enPend.rx) code = ISR_RXRDY;
    else if (enPend.tx) code = ISR_TXRDY;
    else                code = ISR_NONE;
  end

  always_comb begin
    strobes.clrLine = lsrRead;
    strobes.clrTx   = thrWrite | (isrRead & (code == ISR_TXRDY));
  end

  a_r10_irq_matches_code: assert property (@(posedge clk) disable iff (!rstN)
    irq == (code != ISR_NONE));
  a_r8_line_on_top: assert property (@(posedge clk) disable iff (!rstN)
    (rawPend.line && intEnable[2]) |-> code == ISR_LINE);
  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == 3'b000) |-> !irq);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ERR_W      = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [2:0]       intEnable,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             rxPush,
  input  logic [ERR_W-1:0] errFlags,
  input  logic             txEmpty,
  input  logic             isrRead,
  input  logic             lsrRead,
  input  logic             thrWrite,
  output logic             irqOut,
  output logic [7:0]       isrValue,
  output logic             dataReady
);

  src_vec_t    rawPend;
  irq_strobe_t strobes;
  isr_code_e   code;

  uart_irq_datapath #(.CNT_W(CNT_W), .ERR_W(ERR_W)) uDp (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxCount(rxCount),
    .rxTrigger(rxTrigger), .rxPush(rxPush), .errFlags(errFlags),
    .txEmpty(txEmpty), .strobes(strobes), .rawPend(rawPend),
    .dataRdy(dataReady)
  );

  uart_irq_control uCtl (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .rawPend(rawPend),
    .isrRead(isrRead), .lsrRead(lsrRead), .thrWrite(thrWrite),
    .strobes(strobes), .code(code), .irq(irqOut)
  );

  assign isrValue = {{2{fifoEn}}, 2'b00, code};

  a_r6_read_keeps_hidden_tx: assert property (@(posedge clk) disable iff (!rstN)
    (isrRead && !thrWrite && rawPend.tx && isrValue[3:0] != 4'b0010)
      |=> rawPend.tx);
  a_r6_write_clears_tx: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !(txEmpty && !$past(txEmpty))) |=> !rawPend.tx || txEmpty);

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN;
  logic fifoEn;
  logic [2:0] intEnable;
  logic [CNT_W-1:0] rxCount, rxTrigger;
  logic rxPush;
  logic [3:0] errFlags;
  logic txEmpty, isrRead, lsrRead, thrWrite;
  logic irqOut, dataReady;
  logic [7:0] isrValue;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .intEnable(intEnable),
    .rxCount(rxCount), .rxTrigger(rxTrigger), .rxPush(rxPush),
    .errFlags(errFlags), .txEmpty(txEmpty), .isrRead(isrRead),
    .lsrRead(lsrRead), .thrWrite(thrWrite), .irqOut(irqOut),
    .isrValue(isrValue), .dataReady(dataReady)
  );

  // {fifoEn, intEnable, rxCount, rxTrigger, expCode, expIrq}
  localparam int NV = 10;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {1'b1, 3'b001, 5'd4,  5'd4,  4'b0100, 1'b1},
    {1'b1, 3'b001, 5'd3,  5'd4,  4'b0001, 1'b0},
    {1'b1, 3'b001, 5'd16, 5'd14, 4'b0100, 1'b1},
    {1'b1, 3'b001, 5'd0,  5'd1,  4'b0001, 1'b0},
    {1'b0, 3'b001, 5'd1,  5'd14, 4'b0100, 1'b1},
    {1'b0, 3'b001, 5'd0,  5'd1,  4'b0001, 1'b0},
    {1'b1, 3'b000, 5'd8,  5'd4,  4'b0001, 1'b0},
    {1'b1, 3'b110, 5'd8,  5'd4,  4'b0001, 1'b0},
    {1'b0, 3'b001, 5'd5,  5'd8,  4'b0100, 1'b1},
    {1'b1, 3'b001, 5'd5,  5'd8,  4'b0001, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; fifoEn = 1'b1; intEnable = 3'b000; rxCount = '0; rxTrigger = 5'd1;
    rxPush = 1'b0; errFlags = '0; txEmpty = 1'b1; isrRead = 1'b0; lsrRead = 1'b0;
    thrWrite = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    intEnable = 3'b111;
    tick();
    // R1: reset state; txEmpty high across reset latches nothing (R5)
    chk("R1 code", isrValue[3:0], 4'b0001);
    chk("R1 irq", irqOut, 1'b0);
    chk("R1 dataReady", dataReady, 1'b0);
    txEmpty = 1'b0;
    tick();

    // vector table: receive level, modes, enables (R2 R3 R9 R10)
    for (int i = 0; i < NV; i++) begin
      {fifoEn, intEnable, rxCount, rxTrigger} = VEC[i][18:5];
      settle();
      chk("R2/R3 vec code", isrValue[3:0], VEC[i][4:1]);
      chk("R10 vec irq", irqOut, VEC[i][0]);
      chk("R10 vec top bits", isrValue[7:4], {{2{VEC[i][18]}}, 2'b00});
      tick();
    end

    // R4: data ready
    fifoEn = 1'b1; intEnable = 3'b000; rxTrigger = 5'd8;
    rxPush = 1'b1; rxCount = 5'd0;
    tick();
    chk("R4 set on push", dataReady, 1'b1);
    rxPush = 1'b0; rxCount = 5'd2;
    tick();
    chk("R4 held below trigger", dataReady, 1'b1);
    rxCount = 5'd0;
    tick();
    chk("R4 clear when empty", dataReady, 1'b0);

    // R5/R6: transmit event, cleared by THR write
    intEnable = 3'b010;
    txEmpty = 1'b1;
    tick();
    chk("R5 tx code", isrValue[3:0], 4'b0010);
    chk("R5 tx irq", irqOut, 1'b1);
    tick();
    chk("R5 tx stays", isrValue[3:0], 4'b0010);
    thrWrite = 1'b1; txEmpty = 1'b0;
    tick();
    thrWrite = 1'b0;
    chk("R6 thr write clears", isrValue[3:0], 4'b0001);

    // R6: isr read clears when tx is on top
    txEmpty = 1'b1;
    tick();
    chk("R5 tx again", isrValue[3:0], 4'b0010);
    isrRead = 1'b1;
    tick();
    isrRead = 1'b0;
    chk("R6 isr read clears tx", isrValue[3:0], 4'b0001);

    // R6: isr read while rx hides tx keeps tx
    txEmpty = 1'b0;
    tick();
    txEmpty = 1'b1;
    tick();
    intEnable = 3'b011; rxCount = 5'd8; rxTrigger = 5'd4;
    settle();
    chk("R8 rx over tx", isrValue[3:0], 4'b0100);
    isrRead = 1'b1;
    tick();
    isrRead = 1'b0; rxCount = 5'd0;
    settle();
    chk("R6 hidden tx kept", isrValue[3:0], 4'b0010);
    tick();
    isrRead = 1'b1;
    tick();
    isrRead = 1'b0;

    // R7: line errors
    intEnable = 3'b100;
    errFlags = 4'b0010;
    tick();
    errFlags = '0;
    chk("R7 line code", isrValue[3:0], 4'b0110);
    chk("R7 line irq", irqOut, 1'b1);
    lsrRead = 1'b1;
    tick();
    lsrRead = 1'b0;
    chk("R7 lsr read clears", isrValue[3:0], 4'b0001);
    lsrRead = 1'b1; errFlags = 4'b1000;
    tick();
    lsrRead = 1'b0; errFlags = '0;
    chk("R7 same-cycle error kept", isrValue[3:0], 4'b0110);
    lsrRead = 1'b1;
    tick();
    lsrRead = 1'b0;
    chk("R7 cleared after", isrValue[3:0], 4'b0001);

    // R8: full priority walk
    intEnable = 3'b111;
    txEmpty = 1'b0;
    tick();
    txEmpty = 1'b1; errFlags = 4'b0001; rxCount = 5'd6; rxTrigger = 5'd6;
    tick();
    errFlags = '0;
    chk("R8 line first", isrValue[3:0], 4'b0110);
    lsrRead = 1'b1;
    tick();
    lsrRead = 1'b0;
    chk("R8 rx second", isrValue[3:0], 4'b0100);
    rxCount = 5'd5;
    settle();
    chk("R8 tx third", isrValue[3:0], 4'b0010);
    thrWrite = 1'b1;
    tick();
    thrWrite = 1'b0;
    chk("R8 none", isrValue[3:0], 4'b0001);
    chk("R10 irq low", irqOut, 1'b0);

    // R9: tx latched while disabled appears on enable
    intEnable = 3'b000;
    txEmpty = 1'b0;
    tick();
    txEmpty = 1'b1;
    tick();
    chk("R9 disabled code", isrValue[3:0], 4'b0001);
    chk("R9 disabled irq", irqOut, 1'b0);
    intEnable = 3'b010;
    settle();
    chk("R9 enabled later", isrValue[3:0], 4'b0010);
    chk("R9 irq later", irqOut, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule